// File: doc/BRIEF.md
# Windowed Register File

This block is the register file of a compact 16-bit embedded core whose instructions carry only 3-bit register specifiers. The physical storage is larger than eight registers: it is split into a configurable number of equal windows of eight registers each, and an active-window pointer relocates every specifier into the window currently in use. Code therefore keeps its narrow encoding while the core, taken across all windows, has up to 32 registers.

The block has two combinational read ports and one write port, all addressed by a 3-bit specifier in the active window. Two control operations work alongside them. A window select moves the pointer on the next clock edge. A transfer copies one register into another, where each side is named by an explicit window and specifier, so a value can cross from one window to another in a single cycle. Requests that name a window the configuration does not have are dropped and leave a sticky error flag set.

Top module: `win_regfile`

## Requirements
- R1: After a synchronous active-high reset, the active window is 0, the error flag is low, and every physical register reads as zero.
- R2: A specifier s in window w maps to physical register w*8+s. A write in one window is not visible through the same specifier in any other window.
- R3: Both read ports return, without a clock, the stored value of their own specifier in the active window. Each port is independent of the other.
- R4: When a read port addresses the physical register being written in the same cycle (by an ordinary write or by a transfer), it returns the data being written.
- R5: A window select with a valid window number moves the active window on the clock edge. Reads in the next cycle use the new window. An ordinary write issued in the same cycle as the select lands in the old window. With no select, the active window holds.
- R6: A window select naming a window number at or above NUM_WIN leaves the active window unchanged and sets the error flag. The flag stays set until reset.
- R7: A transfer copies the source register (window, specifier) into the destination register (window, specifier) in one cycle. The copied value can be read from the next cycle on.
- R8: If an ordinary write and a transfer are requested in the same cycle, only the transfer is performed and the ordinary write is dropped.
- R9: A transfer whose source or destination window is at or above NUM_WIN writes nothing, drops any ordinary write in that cycle, and sets the error flag.
- R10: NUM_WIN may be 1 to 4. The window fields are clog2(NUM_WIN) bits wide, with a minimum of 1 bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_spec | input | 3 | Read port A specifier in the active window |
| rd_a_data | output | 16 | Read port A data |
| rd_b_spec | input | 3 | Read port B specifier in the active window |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Ordinary write enable |
| wr_spec | input | 3 | Ordinary write specifier in the active window |
| wr_data | input | 16 | Ordinary write data |
| sel_en | input | 1 | Window select request |
| sel_win | input | WIN_W | Window number to make active |
| xfer_en | input | 1 | Transfer request |
| xfer_src_win | input | WIN_W | Transfer source window |
| xfer_src_spec | input | 3 | Transfer source specifier |
| xfer_dst_win | input | WIN_W | Transfer destination window |
| xfer_dst_spec | input | 3 | Transfer destination specifier |
| cur_win | output | WIN_W | Active window number |
| win_err | output | 1 | Sticky flag for a request that named a missing window |

## Verification
The bench builds the block with NUM_WIN set to 3. The window field is then 2 bits wide but one of its codes, window 3, has no storage, so the rejection paths for both the select and the transfer can be reached from the ports. Three populated windows also let a transfer move data between two windows that are both inactive, and let isolation be checked across more than one pair of windows.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int DATA_W     = 16;
    localparam int SPEC_W     = 3;
    localparam int WIN_REGS   = 8;
    localparam int MAX_WIN    = 4;
    localparam int MAX_WIN_W  = 2;
    localparam int PIDX_W     = MAX_WIN_W + SPEC_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SPEC_W-1:0] spec_t;
    typedef logic [MAX_WIN_W-1:0] winx_t;
    typedef logic [PIDX_W-1:0] pidx_t;

    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_PORT = 2'd1,
        WSRC_XFER = 2'd2
    } wsrc_e;

    typedef struct packed {
        logic  en;
        pidx_t idx;
        word_t data;
    } wreq_t;

    function automatic int win_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic pidx_t phys_idx(winx_t w, spec_t s);
        return {w, s};
    endfunction

endpackage

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl #(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_en,
    input  logic [WIN_W-1:0] sel_win,
    input  logic             xfer_bad,
    output logic [WIN_W-1:0] cur_win,
    output logic             err
);
    logic sel_ok;

    assign sel_ok = (int'(sel_win) < NUM_WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_win <= '0;
            err     <= 1'b0;
        end else begin
            if (sel_en) begin
                if (sel_ok) cur_win <= sel_win;
                else        err     <= 1'b1;
            end
            if (xfer_bad) err <= 1'b1;
        end
    end
endmodule

// File: rtl/wrf_wr_arb.sv
module wrf_wr_arb
    import wrf_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2
) (
    input  logic [WIN_W-1:0] cur_win,
    input  logic             wr_en,
    input  spec_t            wr_spec,
    input  word_t            wr_data,
    input  logic             xfer_en,
    input  logic [WIN_W-1:0] xfer_src_win,
    input  spec_t            xfer_src_spec,
    input  logic [WIN_W-1:0] xfer_dst_win,
    input  spec_t            xfer_dst_spec,
    input  word_t            src_q,
    output pidx_t            src_idx,
    output logic             xfer_bad,
    output wreq_t            req
);
    wsrc_e src_sel;
    logic  src_ok;
    logic  dst_ok;

    assign src_ok   = (int'(xfer_src_win) < NUM_WIN);
    assign dst_ok   = (int'(xfer_dst_win) < NUM_WIN);
    assign xfer_bad = xfer_en && !(src_ok && dst_ok);
    assign src_idx  = phys_idx(MAX_WIN_W'(xfer_src_win), xfer_src_spec);

    always_comb begin
        if (xfer_en)      src_sel = xfer_bad ? WSRC_NONE : WSRC_XFER;
        else if (wr_en)   src_sel = WSRC_PORT;
        else              src_sel = WSRC_NONE;
    end

    always_comb begin
        req = '0;
        case (src_sel)
            WSRC_XFER: begin
                req.en   = 1'b1;
                req.idx  = phys_idx(MAX_WIN_W'(xfer_dst_win), xfer_dst_spec);
                req.data = src_q;
            end
            WSRC_PORT: begin
                req.en   = 1'b1;
                req.idx  = phys_idx(MAX_WIN_W'(cur_win), wr_spec);
                req.data = wr_data;
            end
            default: req = '0;
        endcase
    end
endmodule

// File: rtl/wrf_store.sv
module wrf_store
    import wrf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NRD      = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  wreq_t req,
    input  pidx_t rd_idx [NRD],
    output word_t rd_q   [NRD]
);
    word_t mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (req.en && (int'(req.idx) < NUM_REGS)) begin
            mem[int'(req.idx)] <= req.data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_q[p] = (int'(rd_idx[p]) < NUM_REGS) ? mem[int'(rd_idx[p])] : '0;
    end
endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port
    import wrf_pkg::*;
(
    input  pidx_t idx,
    input  word_t stored,
    input  wreq_t req,
    output word_t data
);
    assign data = (req.en && (req.idx == idx)) ? req.data : stored;
endmodule

// File: rtl/win_regfile.sv
module win_regfile
    import wrf_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = wrf_pkg::win_width(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       rd_a_spec,
    output logic [15:0]      rd_a_data,
    input  logic [2:0]       rd_b_spec,
    output logic [15:0]      rd_b_data,
    input  logic             wr_en,
    input  logic [2:0]       wr_spec,
    input  logic [15:0]      wr_data,
    input  logic             sel_en,
    input  logic [WIN_W-1:0] sel_win,
    input  logic             xfer_en,
    input  logic [WIN_W-1:0] xfer_src_win,
    input  logic [2:0]       xfer_src_spec,
    input  logic [WIN_W-1:0] xfer_dst_win,
    input  logic [2:0]       xfer_dst_spec,
    output logic [WIN_W-1:0] cur_win,
    output logic             win_err
);
    localparam int NUM_REGS = NUM_WIN * WIN_REGS;
    localparam int NRD      = 3;
    localparam int NPORT    = 2;

    wreq_t req;
    pidx_t src_idx;
    logic  xfer_bad;
    pidx_t rd_idx [NRD];
    word_t rd_q   [NRD];
    spec_t port_spec [NPORT];
    word_t port_data [NPORT];

    wrf_win_ctrl #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_en   (sel_en),
        .sel_win  (sel_win),
        .xfer_bad (xfer_bad),
        .cur_win  (cur_win),
        .err      (win_err)
    );

    wrf_wr_arb #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_arb (
        .cur_win       (cur_win),
        .wr_en         (wr_en),
        .wr_spec       (wr_spec),
        .wr_data       (wr_data),
        .xfer_en       (xfer_en),
        .xfer_src_win  (xfer_src_win),
        .xfer_src_spec (xfer_src_spec),
        .xfer_dst_win  (xfer_dst_win),
        .xfer_dst_spec (xfer_dst_spec),
        .src_q         (rd_q[NPORT]),
        .src_idx       (src_idx),
        .xfer_bad      (xfer_bad),
        .req           (req)
    );

    assign port_spec[0] = rd_a_spec;
    assign port_spec[1] = rd_b_spec;
    assign rd_idx[NPORT] = src_idx;

    wrf_store #(.NUM_REGS(NUM_REGS), .NRD(NRD)) u_store (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .rd_idx (rd_idx),
        .rd_q   (rd_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign rd_idx[p] = phys_idx(MAX_WIN_W'(cur_win), port_spec[p]);
        wrf_read_port u_rp (
            .idx    (rd_idx[p]),
            .stored (rd_q[p]),
            .req    (req),
            .data   (port_data[p])
        );
    end

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       rd_a_spec,
    input logic [15:0]      rd_a_data,
    input logic             wr_en,
    input logic [2:0]       wr_spec,
    input logic [15:0]      wr_data,
    input logic             sel_en,
    input logic [WIN_W-1:0] sel_win,
    input logic             xfer_en,
    input logic [WIN_W-1:0] xfer_src_win,
    input logic [WIN_W-1:0] xfer_dst_win,
    input logic [WIN_W-1:0] cur_win,
    input logic             win_err
);
    logic sel_ok;
    logic xfer_bad;

    assign sel_ok   = int'(sel_win) < NUM_WIN;
    assign xfer_bad = xfer_en && ((int'(xfer_src_win) >= NUM_WIN) || (int'(xfer_dst_win) >= NUM_WIN));

    assert_sel_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_en && sel_ok) |=> (cur_win == $past(sel_win)));

    assert_win_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !sel_en |=> $stable(cur_win));

    assert_bad_sel_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_en && !sel_ok) |=> ($stable(cur_win) && win_err));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        win_err |=> win_err);

    assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !xfer_en && (rd_a_spec == wr_spec)) |-> (rd_a_data == wr_data));

    assert_bad_xfer_R9: assert property (@(posedge clk) disable iff (rst)
        xfer_bad |=> win_err);
endmodule

bind win_regfile win_regfile_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_a_spec    (rd_a_spec),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_spec      (wr_spec),
    .wr_data      (wr_data),
    .sel_en       (sel_en),
    .sel_win      (sel_win),
    .xfer_en      (xfer_en),
    .xfer_src_win (xfer_src_win),
    .xfer_dst_win (xfer_dst_win),
    .cur_win      (cur_win),
    .win_err      (win_err)
);

// File: tb/test_win_regfile.sv
module test_win_regfile;
    localparam int NUM_WIN = 3;
    localparam int WIN_W   = 2;

    // vector: {op[1:0], win[1:0], spec[2:0], pad, data[15:0]}
    // op 0 = write active window, 1 = select window, 2 = check port A and cur_win
    localparam int NVEC = 12;
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 3'd1, 1'b0, 16'h1111},
        {2'd1, 2'd1, 3'd0, 1'b0, 16'h0000},
        {2'd0, 2'd0, 3'd1, 1'b0, 16'h2222},
        {2'd2, 2'd1, 3'd1, 1'b0, 16'h2222},
        {2'd1, 2'd2, 3'd0, 1'b0, 16'h0000},
        {2'd0, 2'd0, 3'd7, 1'b0, 16'h7777},
        {2'd2, 2'd2, 3'd7, 1'b0, 16'h7777},
        {2'd1, 2'd0, 3'd0, 1'b0, 16'h0000},
        {2'd2, 2'd0, 3'd1, 1'b0, 16'h1111},
        {2'd2, 2'd0, 3'd7, 1'b0, 16'h0000},
        {2'd1, 2'd1, 3'd0, 1'b0, 16'h0000},
        {2'd2, 2'd1, 3'd1, 1'b0, 16'h2222}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       rd_a_spec = '0;
    logic [15:0]      rd_a_data;
    logic [2:0]       rd_b_spec = '0;
    logic [15:0]      rd_b_data;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_spec = '0;
    logic [15:0]      wr_data = '0;
    logic             sel_en = 1'b0;
    logic [WIN_W-1:0] sel_win = '0;
    logic             xfer_en = 1'b0;
    logic [WIN_W-1:0] xfer_src_win = '0;
    logic [2:0]       xfer_src_spec = '0;
    logic [WIN_W-1:0] xfer_dst_win = '0;
    logic [2:0]       xfer_dst_spec = '0;
    logic [WIN_W-1:0] cur_win;
    logic             win_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    win_regfile #(.NUM_WIN(NUM_WIN)) i_win_regfile (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; sel_en = 1'b0; xfer_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 cur_win", 16'(cur_win), 16'd0);
        chk("R1 err", 16'(win_err), 16'd0);
        for (int s = 0; s < 8; s++) begin
            rd_a_spec = 3'(s);
            #1 chk("R1 reg clear", rd_a_data, 16'h0000);
        end

        // R2, R3, R5: table walk
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][23:22])
                2'd0: begin
                    wr_en = 1'b1; wr_spec = VEC[v][19:17]; wr_data = VEC[v][15:0];
                    step();
                end
                2'd1: begin
                    sel_en = 1'b1; sel_win = VEC[v][21:20];
                    step();
                end
                default: begin
                    rd_a_spec = VEC[v][19:17];
                    #1;
                    chk("R2 window map", rd_a_data, VEC[v][15:0]);
                    chk("R5 active window", 16'(cur_win), 16'(VEC[v][21:20]));
                end
            endcase
        end

        // R4: write-first bypass in active window 1
        wr_en = 1'b1; wr_spec = 3'd3; wr_data = 16'h3333; rd_b_spec = 3'd3;
        #1 chk("R4 bypass", rd_b_data, 16'h3333);
        step();
        #1 chk("R3 port B stored", rd_b_data, 16'h3333);

        // R5: write alongside a select lands in the old window
        sel_en = 1'b1; sel_win = 2'd2; wr_en = 1'b1; wr_spec = 3'd5; wr_data = 16'h5555;
        step();
        rd_a_spec = 3'd5;
        #1 chk("R5 new window read", rd_a_data, 16'h0000);
        sel_en = 1'b1; sel_win = 2'd1;
        step();
        #1 chk("R5 write in old window", rd_a_data, 16'h5555);

        // R7: transfer from inactive window 2 into active window 1, with bypass
        xfer_en = 1'b1; xfer_src_win = 2'd2; xfer_src_spec = 3'd7;
        xfer_dst_win = 2'd1; xfer_dst_spec = 3'd6; rd_a_spec = 3'd6;
        #1 chk("R4 transfer bypass", rd_a_data, 16'h7777);
        step();
        #1 chk("R7 transfer result", rd_a_data, 16'h7777);

        // R8: transfer between two inactive windows wins over a write
        xfer_en = 1'b1; xfer_src_win = 2'd0; xfer_src_spec = 3'd1;
        xfer_dst_win = 2'd2; xfer_dst_spec = 3'd0;
        wr_en = 1'b1; wr_spec = 3'd2; wr_data = 16'hBEEF;
        step();
        rd_a_spec = 3'd2;
        #1 chk("R8 write dropped", rd_a_data, 16'h0000);
        sel_en = 1'b1; sel_win = 2'd2;
        step();
        rd_a_spec = 3'd0; rd_b_spec = 3'd7;
        #1;
        chk("R7 cross-window copy", rd_a_data, 16'h1111);
        chk("R3 port B independent", rd_b_data, 16'h7777);

        // R6, R10: window 3 is encodable but absent
        chk("R6 err before", 16'(win_err), 16'd0);
        sel_en = 1'b1; sel_win = 2'd3;
        step();
        chk("R6 window kept", 16'(cur_win), 16'd2);
        chk("R6 err set", 16'(win_err), 16'd1);
        sel_en = 1'b1; sel_win = 2'd0;
        step();
        chk("R6 err sticky", 16'(win_err), 16'd1);
        chk("R10 last window valid", 16'(cur_win), 16'd0);

        // R9: transfer naming window 3 is ignored
        do_reset();
        chk("R1 err cleared", 16'(win_err), 16'd0);
        wr_en = 1'b1; wr_spec = 3'd4; wr_data = 16'h4444;
        step();
        xfer_en = 1'b1; xfer_src_win = 2'd3; xfer_src_spec = 3'd4;
        xfer_dst_win = 2'd0; xfer_dst_spec = 3'd6;
        wr_en = 1'b1; wr_spec = 3'd5; wr_data = 16'hAAAA;
        step();
        rd_a_spec = 3'd6; rd_b_spec = 3'd5;
        #1;
        chk("R9 dest untouched", rd_a_data, 16'h0000);
        chk("R9 write dropped", rd_b_data, 16'h0000);
        chk("R9 err set", 16'(win_err), 16'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule